// File: doc/BRIEF.md
# Lookahead Way Partition Allocator

This block divides the ways of a shared set-associative cache among several applications. Each application has a cumulative hit curve: the number of hits it would have seen with 1, 2, ... up to all ways of the cache. The curves are gathered elsewhere and presented as one flat input vector. A start pulse launches a multi-cycle computation. At the end the block publishes how many ways each application receives and raises a one-cycle done strobe. The way masks in the cache are updated by other logic. The curves and the start pulse come from a periodic trigger, typically every few million cycles.

The computation first gives every application one way. The spare ways are then handed out in rounds. In each round every application and every extra allocation size, from one way up to all ways still unassigned, is evaluated. The pair with the best hit gain per added way wins, and it receives exactly that many ways. Because a step of several ways is rated as a whole, an application whose benefit only appears after a few extra ways can still win. A one-way-at-a-time allocator would pass it over on a non-convex curve. Ratios are compared by cross-multiplication, so the block needs no divider.

Top module: `lookahead_way_alloc`

## Requirements
- R1: After reset, `ways_o` is all zero, and `busy_o` and `done_o` are low.
- R2: A start pulse while the block is idle makes `busy_o` high on the next cycle. A start pulse while busy is ignored: the run in progress finishes with its own result and a single done strobe.
- R3: Every application ends with at least one way, and the allotments sum to `N_WAYS`.
- R4: The hit count for application a with k ways (1..N_WAYS) sits at `curves_i[(a*N_WAYS+k-1)*CNT_W +: CNT_W]`, and zero ways means zero hits. The gain from k to m ways is H(m)−H(k), or 0 when H(m) < H(k).
- R5: Each round considers every application and every extra size s from 1 to the ways still unassigned. It grants exactly s ways to the pair that maximizes gain/s. Rounds repeat until no way is left.
- R6: Ties in gain/s go to the lower application index first, then to the smaller extra size.
- R7: With four applications and 16 ways, take these curves: application 0 gains 10 per way; application 1 has 0 hits at one way and 80 from four ways on; applications 2 and 3 are flat. The result is 10, 4, 1, 1 ways.
- R8: `done_o` is high for exactly one cycle, with `busy_o` low in that cycle. `ways_o` changes only in the cycle `done_o` rises and holds afterwards, even if the curves change.
- R9: The start is taken at clock edge 0. Let rem be the number of unassigned ways at the beginning of each round. `done_o` goes high after edge 1 + Σ over the rounds of (N_APPS·rem + 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse; taken only while idle |
| curves_i | input | N_APPS*N_WAYS*CNT_W | Cumulative hit curves, one CNT_W count per application and way count |
| ways_o | output | N_APPS*WAY_W | Ways granted per application, WAY_W bits each, application 0 in the low bits |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle strobe when new allotments are published |

## Verification
The bench aims at the non-convex case. There, a one-way-at-a-time allocator would hand nearly every way to the steady application and miss the 3-way cliff. All-flat and quantized curves create ties; a wrong tie rule would favour a higher index or a longer step. Random curves that fall as well as rise check saturation, since a wrapped subtraction would make a falling curve look like a large gain. The bench also fires a second start mid-run and changes the curves after completion: a design that restarted, or that let its outputs follow internal state, would then show a second done strobe, a late done, or drifting outputs.

// File: rtl/lwp_pkg.sv
// Package lwp_pkg
// Holds the control-state encoding shared by the allocator modules.
// Assumes no other package defines these names.
package lwp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_GRANT = 2'd2,
        ST_FIN   = 2'd3
    } lwp_state_e;
endpackage

// File: rtl/lwp_ledger.sv
// Module lwp_ledger
// Keeps the running allotment per application and the count of ways not
// yet handed out. An init pulse gives every application one way. A grant
// pulse adds grant_len_i ways to one application.
// Assumes N_WAYS >= N_APPS and that a grant never exceeds remain_o.
module lwp_ledger #(
    parameter int N_APPS = 4,
    parameter int N_WAYS = 16,
    parameter int WAY_W  = 5,
    parameter int APP_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      init_i,
    input  logic                      grant_i,
    input  logic [APP_W-1:0]          grant_app_i,
    input  logic [WAY_W-1:0]          grant_len_i,
    output logic [N_APPS*WAY_W-1:0]   alloc_o,
    output logic [WAY_W-1:0]          remain_o
);
    localparam logic [WAY_W-1:0] SPARE = WAY_W'(N_WAYS - N_APPS);

    logic [WAY_W-1:0] alloc_q [N_APPS];

    for (genvar g = 0; g < N_APPS; g++) begin : g_app
        // Per-application allotment register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                alloc_q[g] <= '0;
            end else if (init_i) begin
                alloc_q[g] <= WAY_W'(1);
            end else if (grant_i && (grant_app_i == APP_W'(g))) begin
                alloc_q[g] <= alloc_q[g] + grant_len_i;
            end
        end
        assign alloc_o[g*WAY_W +: WAY_W] = alloc_q[g];
    end

    // Count of ways still unassigned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_o <= '0;
        end else if (init_i) begin
            remain_o <= SPARE;
        end else if (grant_i) begin
            remain_o <= remain_o - grant_len_i;
        end
    end
endmodule

// File: rtl/lwp_gain_pick.sv
// Module lwp_gain_pick
// Combinational: reads the hit curve of one application and returns the
// hit gain of growing from base_i ways to base_i+extra_i ways, clamped at
// zero when the curve falls.
// Assumes base_i + extra_i <= N_WAYS whenever the result is used.
module lwp_gain_pick #(
    parameter int N_APPS = 4,
    parameter int N_WAYS = 16,
    parameter int CNT_W  = 16,
    parameter int WAY_W  = 5,
    parameter int APP_W  = 2
) (
    input  logic [N_APPS*N_WAYS*CNT_W-1:0] curves_i,
    input  logic [APP_W-1:0]               app_i,
    input  logic [WAY_W-1:0]               base_i,
    input  logic [WAY_W-1:0]               extra_i,
    output logic [CNT_W-1:0]               gain_o
);
    logic [WAY_W:0]   top_k;
    logic [CNT_W-1:0] top_hits;
    logic [CNT_W-1:0] base_hits;
    int               top_idx;
    int               base_idx;

    // Look up both curve points and form the clamped difference.
    always_comb begin
        top_k    = {1'b0, base_i} + {1'b0, extra_i};
        top_idx  = (int'(app_i) * N_WAYS + int'(top_k) - 1) * CNT_W;
        base_idx = (int'(app_i) * N_WAYS + int'(base_i) - 1) * CNT_W;
        top_hits  = (top_k == '0) ? '0 : curves_i[top_idx +: CNT_W];
        base_hits = (base_i == '0) ? '0 : curves_i[base_idx +: CNT_W];
        gain_o    = (top_hits > base_hits) ? (top_hits - base_hits) : '0;
    end
endmodule

// File: rtl/lwp_mu_cmp.sv
// Module lwp_mu_cmp
// Combinational: decides whether a candidate (gain, length) beats the
// stored best in gain per way. It uses cross products, so no divider is
// needed. Equal ratios keep the stored best. An empty best is always
// replaced.
// Assumes lengths are nonzero.
module lwp_mu_cmp #(
    parameter int CNT_W = 16,
    parameter int WAY_W = 5
) (
    input  logic [CNT_W-1:0] cand_gain_i,
    input  logic [WAY_W-1:0] cand_len_i,
    input  logic [CNT_W-1:0] best_gain_i,
    input  logic [WAY_W-1:0] best_len_i,
    input  logic             best_valid_i,
    output logic             take_o
);
    localparam int PW = CNT_W + WAY_W;

    logic [PW-1:0] cand_x;
    logic [PW-1:0] best_x;

    // Cross-multiply and compare strictly.
    always_comb begin
        cand_x = PW'(cand_gain_i) * PW'(best_len_i);
        best_x = PW'(best_gain_i) * PW'(cand_len_i);
        take_o = !best_valid_i || (cand_x > best_x);
    end
endmodule

// File: rtl/lookahead_way_alloc.sv
// Module lookahead_way_alloc
// Splits N_WAYS cache ways among N_APPS applications from their
// cumulative hit curves. It grants one way to each application first.
// Then it runs lookahead rounds: each round scans every (application,
// extra size) pair, one per cycle, and grants the best gain-per-way step.
// Results are published to ways_o with a one-cycle done_o.
// Assumes curves_i is stable while busy_o is high and N_WAYS >= N_APPS.
module lookahead_way_alloc #(
    parameter int N_APPS = 4,
    parameter int N_WAYS = 16,
    parameter int CNT_W  = 16,
    parameter int WAY_W  = $clog2(N_WAYS + 1),
    parameter int APP_W  = (N_APPS > 1) ? $clog2(N_APPS) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start_i,
    input  logic [N_APPS*N_WAYS*CNT_W-1:0]  curves_i,
    output logic [N_APPS*WAY_W-1:0]         ways_o,
    output logic                            busy_o,
    output logic                            done_o
);
    import lwp_pkg::*;

    localparam logic [APP_W-1:0] LAST_APP = APP_W'(N_APPS - 1);
    localparam bit               NO_SPARE = (N_WAYS == N_APPS);

    lwp_state_e              state_q;
    logic [APP_W-1:0]        cur_app_q;
    logic [WAY_W-1:0]        cur_ext_q;
    logic [APP_W-1:0]        best_app_q;
    logic [WAY_W-1:0]        best_len_q;
    logic [CNT_W-1:0]        best_gain_q;
    logic                    best_valid_q;

    logic                    init_p;
    logic                    grant_p;
    logic [N_APPS*WAY_W-1:0] alloc_w;
    logic [WAY_W-1:0]        remain_w;
    logic [WAY_W-1:0]        base_w;
    logic [CNT_W-1:0]        cand_gain_w;
    logic                    take_w;

    assign init_p  = (state_q == ST_IDLE) && start_i;
    assign grant_p = (state_q == ST_GRANT);
    assign base_w  = alloc_w[int'(cur_app_q)*WAY_W +: WAY_W];
    assign busy_o  = (state_q != ST_IDLE);

    lwp_ledger #(
        .N_APPS(N_APPS), .N_WAYS(N_WAYS), .WAY_W(WAY_W), .APP_W(APP_W)
    ) u_ledger (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (init_p),
        .grant_i    (grant_p),
        .grant_app_i(best_app_q),
        .grant_len_i(best_len_q),
        .alloc_o    (alloc_w),
        .remain_o   (remain_w)
    );

    lwp_gain_pick #(
        .N_APPS(N_APPS), .N_WAYS(N_WAYS), .CNT_W(CNT_W),
        .WAY_W(WAY_W), .APP_W(APP_W)
    ) u_gain (
        .curves_i(curves_i),
        .app_i   (cur_app_q),
        .base_i  (base_w),
        .extra_i (cur_ext_q),
        .gain_o  (cand_gain_w)
    );

    lwp_mu_cmp #(
        .CNT_W(CNT_W), .WAY_W(WAY_W)
    ) u_cmp (
        .cand_gain_i (cand_gain_w),
        .cand_len_i  (cur_ext_q),
        .best_gain_i (best_gain_q),
        .best_len_i  (best_len_q),
        .best_valid_i(best_valid_q),
        .take_o      (take_w)
    );

    // Control sequence: idle, scan candidates, grant, publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            cur_app_q    <= '0;
            cur_ext_q    <= WAY_W'(1);
            best_valid_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q      <= NO_SPARE ? ST_FIN : ST_SCAN;
                        cur_app_q    <= '0;
                        cur_ext_q    <= WAY_W'(1);
                        best_valid_q <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    best_valid_q <= 1'b1;
                    if (cur_ext_q == remain_w) begin
                        cur_ext_q <= WAY_W'(1);
                        if (cur_app_q == LAST_APP) begin
                            state_q <= ST_GRANT;
                        end else begin
                            cur_app_q <= cur_app_q + APP_W'(1);
                        end
                    end else begin
                        cur_ext_q <= cur_ext_q + WAY_W'(1);
                    end
                end
                ST_GRANT: begin
                    cur_app_q    <= '0;
                    cur_ext_q    <= WAY_W'(1);
                    best_valid_q <= 1'b0;
                    state_q      <= (remain_w == best_len_q) ? ST_FIN : ST_SCAN;
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Best candidate of the current round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_app_q  <= '0;
            best_len_q  <= WAY_W'(1);
            best_gain_q <= '0;
        end else if (state_q == ST_SCAN && take_w) begin
            best_app_q  <= cur_app_q;
            best_len_q  <= cur_ext_q;
            best_gain_q <= cand_gain_w;
        end
    end

    // Published allotments and done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ways_o <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= (state_q == ST_FIN);
            if (state_q == ST_FIN) begin
                ways_o <= alloc_w;
            end
        end
    end
endmodule

// File: rtl/lwp_checker.sv
// Module lwp_checker
// Property checks on the allocator ports, bound to every instance.
// Assumes synchronous active-low reset.
module lwp_checker #(
    parameter int N_APPS = 4,
    parameter int N_WAYS = 16,
    parameter int WAY_W  = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start_i,
    input logic                     busy_o,
    input logic                     done_o,
    input logic [N_APPS*WAY_W-1:0]  ways_o
);
    function automatic int total_ways(input logic [N_APPS*WAY_W-1:0] v);
        int s = 0;
        for (int i = 0; i < N_APPS; i++) s += int'(v[i*WAY_W +: WAY_W]);
        return s;
    endfunction

    function automatic bit all_nonzero(input logic [N_APPS*WAY_W-1:0] v);
        bit ok = 1'b1;
        for (int i = 0; i < N_APPS; i++) if (v[i*WAY_W +: WAY_W] == '0) ok = 1'b0;
        return ok;
    endfunction

    AST_DONE_FULL:  assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (total_ways(ways_o) == N_WAYS));                      // R3
    AST_DONE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> all_nonzero(ways_o));                                 // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                             // R8
    AST_DONE_IDLE:  assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);                                             // R8
    AST_OUT_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ways_o) |-> done_o);                                    // R8
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);                                // R2
endmodule

bind lookahead_way_alloc lwp_checker #(
    .N_APPS(N_APPS), .N_WAYS(N_WAYS), .WAY_W(WAY_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .ways_o (ways_o)
);

// File: tb/lookahead_way_alloc_tb.sv
module lookahead_way_alloc_tb;
    localparam int NA = 4;
    localparam int NW = 16;
    localparam int CW = 16;
    localparam int WW = $clog2(NW + 1);

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start_i = 1'b0;
    logic [NA*NW*CW-1:0]    curves_i = '0;
    logic [NA*WW-1:0]       ways_o;
    logic                   busy_o;
    logic                   done_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int crv [NA][NW];
    int exp_ways [NA];
    int exp_lat;

    lookahead_way_alloc #(.N_APPS(NA), .N_WAYS(NW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .curves_i(curves_i),
        .ways_o(ways_o), .busy_o(busy_o), .done_o(done_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int hits(input int a, input int k);
        return (k == 0) ? 0 : crv[a][k-1];
    endfunction

    // Reference lookahead from the requirements (R3..R6, R9).
    task automatic model();
        int alloc [NA];
        int rem;
        int ba, bl, bg;
        bit bv;
        for (int a = 0; a < NA; a++) alloc[a] = 1;
        rem = NW - NA;
        exp_lat = 1;
        while (rem > 0) begin
            bv = 0; ba = 0; bl = 1; bg = 0;
            for (int a = 0; a < NA; a++) begin
                for (int s = 1; s <= rem; s++) begin
                    int g = hits(a, alloc[a] + s) - hits(a, alloc[a]);
                    if (g < 0) g = 0;
                    if (!bv || (longint'(g) * bl > longint'(bg) * s)) begin
                        bv = 1; ba = a; bl = s; bg = g;
                    end
                end
            end
            exp_lat += NA * rem + 1;
            alloc[ba] += bl;
            rem -= bl;
        end
        for (int a = 0; a < NA; a++) exp_ways[a] = alloc[a];
    endtask

    task automatic pack();
        for (int a = 0; a < NA; a++)
            for (int k = 0; k < NW; k++)
                curves_i[(a*NW + k)*CW +: CW] = CW'(crv[a][k]);
    endtask

    // Launch one run; optional second start mid-run; check result and latency.
    task automatic run(input string req, input bit extra_start);
        int n = 0;
        pack();
        model();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        check("R2 busy after start", int'(busy_o), 1);
        if (extra_start) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
            n = 4;
        end
        while (n < 5000) begin
            @(posedge clk); #1;
            n++;
            if (done_o) break;
        end
        check("R9 latency", n, exp_lat);
        check("R8 busy low with done", int'(busy_o), 0);
        for (int a = 0; a < NA; a++)
            check(req, int'(ways_o[a*WW +: WW]), exp_ways[a]);
        @(posedge clk); #1;
        check("R8 done single cycle", int'(done_o), 0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 ways reset", int'(ways_o), 0);
        check("R1 busy reset", int'(busy_o), 0);
        check("R1 done reset", int'(done_o), 0);
        @(negedge clk); rst_n = 1'b1;

        // R7 non-convex lookahead case
        for (int k = 1; k <= NW; k++) begin
            crv[0][k-1] = 10 * k;
            crv[1][k-1] = (k >= 4) ? 80 : 0;
            crv[2][k-1] = 0;
            crv[3][k-1] = 0;
        end
        run("R7 lookahead split", 1'b0);
        check("R7 app0", int'(ways_o[0 +: WW]), 10);
        check("R7 app1", int'(ways_o[WW +: WW]), 4);
        check("R3 app3 floor", int'(ways_o[3*WW +: WW]), 1);

        // R8 outputs hold when curves change after completion
        for (int a = 0; a < NA; a++)
            for (int k = 0; k < NW; k++) crv[a][k] = 500 - k;
        pack();
        begin
            int seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(posedge clk); #1;
                if (done_o) seen++;
            end
            check("R8 no spurious done", seen, 0);
            check("R8 hold app0", int'(ways_o[0 +: WW]), 10);
            check("R8 hold app1", int'(ways_o[WW +: WW]), 4);
        end

        // R6 all flat: every round app0 with size 1
        for (int a = 0; a < NA; a++)
            for (int k = 0; k < NW; k++) crv[a][k] = 7;
        run("R6 flat ties", 1'b0);
        check("R6 app0 takes ties", int'(ways_o[0 +: WW]), NW - NA + 1);

        // R4 falling curve on app1 must not look like a gain
        for (int k = 0; k < NW; k++) begin
            crv[0][k] = 3 * (k + 1);
            crv[1][k] = 1000 - 50 * k;
            crv[2][k] = 0;
            crv[3][k] = k;
        end
        run("R4 clamped gain", 1'b0);
        check("R4 app1 stays at one", int'(ways_o[WW +: WW]), 1);

        // R2 second start while busy is ignored
        for (int a = 0; a < NA; a++)
            for (int k = 0; k < NW; k++) crv[a][k] = (a + 1) * (k + 1) * 5;
        run("R2 ignored restart", 1'b1);
        begin
            int seen = 0;
            for (int i = 0; i < 600; i++) begin
                @(posedge clk); #1;
                if (done_o || busy_o) seen++;
            end
            check("R2 no second run", seen, 0);
        end

        // R5 random curves: monotone, arbitrary, quantized (ties R6)
        for (int t = 0; t < 36; t++) begin
            int mode = t % 3;
            for (int a = 0; a < NA; a++) begin
                int acc = 0;
                for (int k = 0; k < NW; k++) begin
                    if (mode == 0) acc += int'($urandom % 60);
                    else if (mode == 1) acc = int'($urandom % 300);
                    else acc += 10 * int'($urandom % 3);
                    crv[a][k] = acc;
                end
            end
            run(mode == 2 ? "R6 random ties" : "R5 random curves", 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule